// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 9-bit words between two unrelated clock domains. A producer stores one word on each rising write-clock edge where its write enable is high, and a consumer takes the next word on each rising read-clock edge where its read enable is high. The read data is registered, so a word shows on the output right after the read edge that fetched it.

Four active-low status pins describe the fill level. Empty and full are exact in their own clock domain. Almost-empty and almost-full compare the fill level with two programmable thresholds and are each registered once in their own domain. The producer's back-pressure signal is the full flag, and the consumer's is the empty flag: a write presented while full is dropped, and a read presented while empty is dropped. Pointers cross the domains as Gray codes through two-flop synchronizers.

The two thresholds sit in four 9-bit registers. These registers are reached through the ordinary data pins while the load control is held low. Writes fill them in a fixed rotating order. Reads return them in the same rotating order, with a separate position counter for reads. Neither kind of access disturbs the stored words. Reset clears both pointers, both rotation counters and the thresholds.

Top module: `dcfifo_pflags`

## Requirements
- R1: Words leave in the order they were stored, bit-exact over all 9 bits. `rd_data` shows a word after the rising `rclk` edge at which `rd_en`, `load_n` and `empty_n` were all high.
- R2: `empty_n` is 0 exactly when no unread word is visible in the read domain. `full_n` is 0 exactly when 2^ADDR_W unread words are visible in the write domain. After the other clock stops moving, both flags settle within a few cycles of their own clock.
- R3: A write while `full_n` is 0 changes neither the pointers nor the stored words. A read while `empty_n` is 0 leaves the pointers and `rd_data` unchanged.
- R4: `afull_n` is 0 when the free space (depth minus unread count) is at most the full threshold, and 1 when the free space exceeds it. A single `wclk` register sits after the pointer, so the flag moves on the second `wclk` edge after the write that crosses the threshold.
- R5: `aempty_n` is 0 when the unread count is at most the empty threshold, and 1 when the count exceeds it. A single `rclk` register sits after the pointer, so the flag moves on the second `rclk` edge after the read that crosses the threshold.
- R6: While `load_n` is 0, each enabled `wclk` edge writes `wr_data` into threshold slot 0, 1, 2, 3, 0, … in turn and never touches the stored words.
  - Slot 0 is the low 9 bits of the empty threshold, and slot 1 is its upper 9 bits (threshold = slot1·512 + slot0).
  - Slots 2 and 3 hold the full threshold in the same way.
- R7: While `load_n` is 0, each enabled `rclk` edge loads the next threshold slot into `rd_data`. The order is slot 0, 1, 2, 3, and then it wraps. The read pointer does not move.
- R8: After reset, `empty_n`=0, `full_n`=1, `aempty_n`=0 and `afull_n`=1. The empty threshold is 7, the full threshold is 0, and both rotation counters point to slot 0.
- R9: Each pointer's Gray code changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| load_n | input | 1 | Low: enables route to threshold slots instead of the buffer |
| wr_en | input | 1 | Write enable, sampled on rising `wclk` |
| wr_data | input | 9 | Word to store, or threshold slot value |
| full_n | output | 1 | Low when the buffer is full (write-domain view) |
| afull_n | output | 1 | Low when free space is at most the full threshold |
| rd_en | input | 1 | Read enable, sampled on rising `rclk` |
| rd_data | output | 9 | Registered read word, or threshold slot value |
| empty_n | output | 1 | Low when the buffer is empty (read-domain view) |
| aempty_n | output | 1 | Low when unread count is at most the empty threshold |

## Verification
The bench builds the block with ADDR_W=4, which gives 16 entries. With this depth, the bench reaches full, overflow, the full threshold and the upper threshold byte in a few dozen writes. The write clock has a 10 ns period and the read clock a 13 ns period, so the synchronizers see drifting phase. The thresholds used range from 0 up to 600. The value 600 exercises the upper 9-bit slot, and it also pushes almost-empty past the depth.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int WORD_W   = 9;
  localparam int SLOTS    = 4;
  localparam int THRESH_W = 2 * WORD_W;
  localparam logic [THRESH_W-1:0] EMPTY_THRESH_RST = THRESH_W'(7);
  localparam logic [THRESH_W-1:0] FULL_THRESH_RST  = '0;
  typedef enum logic [1:0] {
    SLOT_EMPTY_LO = 2'd0,
    SLOT_EMPTY_HI = 2'd1,
    SLOT_FULL_LO  = 2'd2,
    SLOT_FULL_HI  = 2'd3
  } slot_e;
endpackage

// File: rtl/dcf_ptr.sv
module dcf_ptr #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [PW-1:0] bin,
  output logic [PW-1:0] gray
);
  logic [PW-1:0] bin_nxt;
  assign bin_nxt = bin + PW'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin  <= '0;
      gray <= '0;
    end else begin
      bin  <= bin_nxt;
      gray <= bin_nxt ^ (bin_nxt >> 1);
    end
  end

  // R9
  gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray ^ $past(gray)) <= 1);
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_thresh_regs.sv
module dcf_thresh_regs
  import dcfifo_pkg::*;
(
  input  logic                wclk,
  input  logic                rclk,
  input  logic                rst_n,
  input  logic                wr_stb,
  input  logic [WORD_W-1:0]   wr_word,
  input  logic                rd_stb,
  output logic [WORD_W-1:0]   rd_word,
  output logic [THRESH_W-1:0] empty_thresh,
  output logic [THRESH_W-1:0] full_thresh
);
  logic [WORD_W-1:0] slot_q [SLOTS];
  logic [1:0]        wsel, rsel;

  function automatic logic [WORD_W-1:0] slot_rst(input int idx);
    case (idx)
      int'(SLOT_EMPTY_LO): return EMPTY_THRESH_RST[WORD_W-1:0];
      int'(SLOT_EMPTY_HI): return EMPTY_THRESH_RST[THRESH_W-1:WORD_W];
      int'(SLOT_FULL_LO):  return FULL_THRESH_RST[WORD_W-1:0];
      default:             return FULL_THRESH_RST[THRESH_W-1:WORD_W];
    endcase
  endfunction

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slot_q[i] <= slot_rst(i);
      wsel <= '0;
    end else if (wr_stb) begin
      slot_q[wsel] <= wr_word;
      wsel <= wsel + 2'd1;
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)      rsel <= '0;
    else if (rd_stb) rsel <= rsel + 2'd1;
  end

  assign rd_word      = slot_q[rsel];
  assign empty_thresh = {slot_q[SLOT_EMPTY_HI], slot_q[SLOT_EMPTY_LO]};
  assign full_thresh  = {slot_q[SLOT_FULL_HI],  slot_q[SLOT_FULL_LO]};

  // R6
  wsel_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_stb |=> wsel == $past(wsel) + 2'd1);
  // R7
  rsel_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_stb |=> rsel == $past(rsel));
endmodule

// File: rtl/dcfifo_pflags.sv
module dcfifo_pflags
  import dcfifo_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              full_n,
  output logic              afull_n,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty_n,
  output logic              aempty_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WORD_W-1:0]   mem [DEPTH];
  logic [PW-1:0]       wbin, wgray, rbin, rgray, rgray_w, wgray_r;
  logic [PW-1:0]       wcount, wfree, rcount;
  logic [THRESH_W-1:0] empty_thresh, full_thresh;
  logic [WORD_W-1:0]   slot_word;
  logic                wr_buf, wr_slot, rd_buf, rd_slot;
  logic                afull_q, aempty_q;
  logic [WORD_W-1:0]   rd_q;

  // write domain
  assign wr_buf  = wr_en & load_n & full_n;
  assign wr_slot = wr_en & ~load_n;

  dcf_ptr #(.PW(PW)) wptr_i (.clk(wclk), .rst_n(rst_n), .inc(wr_buf), .bin(wbin), .gray(wgray));
  dcf_sync #(.W(PW), .STAGES(2)) r2w_i (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));

  assign wcount = wbin - gray2bin(rgray_w);
  assign wfree  = DEPTH_P - wcount;
  assign full_n = (wcount != DEPTH_P);

  always_ff @(posedge wclk) begin
    if (wr_buf) mem[wbin[ADDR_W-1:0]] <= wr_data;
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) afull_q <= 1'b1;
    else        afull_q <= (THRESH_W'(wfree) > full_thresh);
  end
  assign afull_n = afull_q;

  // read domain
  assign rd_buf  = rd_en & load_n & empty_n;
  assign rd_slot = rd_en & ~load_n;

  dcf_ptr #(.PW(PW)) rptr_i (.clk(rclk), .rst_n(rst_n), .inc(rd_buf), .bin(rbin), .gray(rgray));
  dcf_sync #(.W(PW), .STAGES(2)) w2r_i (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

  assign rcount  = gray2bin(wgray_r) - rbin;
  assign empty_n = (rcount != '0);

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      aempty_q <= 1'b0;
      rd_q     <= '0;
    end else begin
      aempty_q <= (THRESH_W'(rcount) > empty_thresh);
      if (rd_buf)       rd_q <= mem[rbin[ADDR_W-1:0]];
      else if (rd_slot) rd_q <= slot_word;
    end
  end
  assign aempty_n = aempty_q;
  assign rd_data  = rd_q;

  dcf_thresh_regs thresh_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_stb(wr_slot), .wr_word(wr_data),
    .rd_stb(rd_slot), .rd_word(slot_word),
    .empty_thresh(empty_thresh), .full_thresh(full_thresh));

  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_en && load_n && !full_n) |=> wbin == $past(wbin));
  // R3
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_en && load_n && !empty_n) |=> (rbin == $past(rbin)) && $stable(rd_data));
  // R2
  count_bound_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= DEPTH_P);
  // R6
  slot_write_keeps_ptr_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_en && !load_n) |=> wbin == $past(wbin));
endmodule

// File: tb/dcfifo_pflags_tb_top.sv
module dcfifo_pflags_tb_top;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic load_n = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic full_n, afull_n, empty_n, aempty_n;

  always #5 wclk = ~wclk;
  always #6.5 rclk = ~rclk;

  dcfifo_pflags #(.ADDR_W(AW)) dut_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .load_n(load_n),
    .wr_en(wr_en), .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n),
    .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] model[$];
  int e_th = 7, f_th = 0;
  logic [8:0] dval = 9'h0A5;

  // rows: {empty threshold, full threshold, writes, reads}
  localparam logic [63:0] VEC [8] = '{
    {16'd7,   16'd0,  16'd5,  16'd0},
    {16'd3,   16'd2,  16'd9,  16'd0},
    {16'd3,   16'd2,  16'd4,  16'd10},
    {16'd0,   16'd5,  16'd0,  16'd6},
    {16'd600, 16'd1,  16'd3,  16'd5},
    {16'd2,   16'd15, 16'd16, 16'd0},
    {16'd2,   16'd15, 16'd0,  16'd14},
    {16'd1,   16'd0,  16'd1,  16'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge wclk);
    repeat (5) @(negedge rclk);
  endtask

  task automatic check_flags(input string where);
    int cnt = model.size();
    chk({"R2 empty_n ", where}, int'(empty_n), int'(cnt != 0));
    chk({"R2 full_n ", where}, int'(full_n), int'(cnt != DEPTH));
    chk({"R4 afull_n ", where}, int'(afull_n), int'((DEPTH - cnt) > f_th));
    chk({"R5 aempty_n ", where}, int'(aempty_n), int'(cnt > e_th));
  endtask

  task automatic do_writes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wr_en = 1'b1; wr_data = dval;
      if (model.size() < DEPTH) model.push_back(dval);
      dval = dval + 9'd37;
    end
    @(negedge wclk) wr_en = 1'b0;
  endtask

  task automatic do_read();
    logic [8:0] prev;
    @(negedge rclk);
    prev = rd_data; rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
    if (model.size() > 0) chk("R1 read data order", int'(rd_data), int'(model.pop_front()));
    else                  chk("R3 read while empty keeps rd_data", int'(rd_data), int'(prev));
  endtask

  task automatic program_thresh(input int e, input int f);
    logic [8:0] w [4];
    w[0] = e[8:0]; w[1] = e[17:9]; w[2] = f[8:0]; w[3] = f[17:9];
    @(negedge wclk) load_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      wr_en = 1'b1; wr_data = w[i];
      @(negedge wclk);
    end
    wr_en = 1'b0;
    @(negedge rclk);
    for (int i = 0; i < 4; i++) begin
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      chk("R7 slot readback (R6 order)", int'(rd_data), int'(w[i]));
    end
    load_n = 1'b1;
    e_th = e; f_th = f;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #23 rst_n = 1'b1;
    model.delete(); e_th = 7; f_th = 0;
    settle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R8 reset state
    chk("R8 empty_n after reset", int'(empty_n), 0);
    chk("R8 full_n after reset", int'(full_n), 1);
    chk("R8 aempty_n after reset", int'(aempty_n), 0);
    chk("R8 afull_n after reset", int'(afull_n), 1);
    @(negedge rclk) load_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      chk("R8 default slot value", int'(rd_data), (i == 0) ? 7 : 0);
    end
    load_n = 1'b1;

    for (int r = 0; r < 8; r++) begin
      program_thresh(int'(VEC[r][63:48]), int'(VEC[r][47:32]));
      settle();
      check_flags("after threshold load (R6)");
      do_writes(int'(VEC[r][31:16]));
      settle();
      check_flags("after writes");
      for (int k = 0; k < int'(VEC[r][15:0]); k++) do_read();
      settle();
      check_flags("after reads");
    end

    // R1: first word readable once empty_n rises
    do_reset();
    do_writes(1);
    begin
      int waitc = 0;
      while (!empty_n && waitc < 10) begin @(negedge rclk); waitc++; end
      chk("R2 empty_n rises within sync window", int'(waitc <= 4), 1);
    end
    do_read();

    // R4 single-register lag on almost-full
    program_thresh(7, 3);
    do_writes(12);
    settle();
    chk("R4 afull_n high at free 4", int'(afull_n), 1);
    @(negedge wclk) wr_en = 1'b1; wr_data = dval; model.push_back(dval); dval = dval + 9'd1;
    @(negedge wclk) wr_en = 1'b0;
    chk("R4 afull_n one edge after write", int'(afull_n), 1);
    @(negedge wclk);
    chk("R4 afull_n two edges after write", int'(afull_n), 0);

    // R5 single-register lag on almost-empty
    for (int k = 0; k < 5; k++) do_read();
    settle();
    chk("R5 aempty_n high at count 8", int'(aempty_n), 1);
    @(negedge rclk) rd_en = 1'b1;
    @(negedge rclk) rd_en = 1'b0;
    chk("R1 data on lag read", int'(rd_data), int'(model.pop_front()));
    chk("R5 aempty_n one edge after read", int'(aempty_n), 1);
    @(negedge rclk);
    chk("R5 aempty_n two edges after read", int'(aempty_n), 0);
    settle();
    check_flags("end");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule